// File: doc/BRIEF.md
# Load Data Width Extender

This stage sits between the memory read return and the register write port. It takes one raw 64-bit read beat and the low three address bits, picks out the addressed item, and widens it for the destination register. The item can be 1, 2, 4 or 8 bytes wide. A flag selects sign or zero fill, and a second flag selects whether the destination is a 32-bit or a 64-bit view of the register.

For a 32-bit view, the fill stops at bit 31. The upper half of the written value is always zero, even on a sign-filling load. An 8-byte item aimed at a 32-bit view is illegal. It raises an error pulse in place of a valid result.

The result is registered. It appears one clock after the valid strobe. Reset is synchronous and active low.

Top module: `ld_extend`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_vld`, `out_err` and `out_data` become 0.
- R2: `out_vld` is high exactly in the cycle after a legal request (`in_vld` high). When no legal request was taken, `out_vld` is low and `out_data` holds its previous value.
- R3: Lanes are little-endian. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. The item starts at byte `addr_lo` with its low bits cleared to the item's alignment: none for a byte, bit 0 for 2 bytes, bits 1:0 for 4 bytes, and all bits for 8 bytes.
- R4: With `sext` = 0, every bit above the item is zero.
- R5: With `sext` = 1 and `dst64` = 1, every bit above the item copies the item's top bit. For example, byte 0x8A gives 0xFFFFFFFFFFFFFF8A.
- R6: With `dst64` = 0, bits 63:32 of the result are zero. With `sext` = 1, the fill covers only bits 31 up to the item's top. For example, byte 0x8A gives 0x00000000FFFFFF8A.
- R7: A 4-byte item with `sext` = 1 into a 32-bit view gives the same result as the same item with `sext` = 0.
- R8: A size code of 3 with `dst64` = 0 makes `out_err` high and `out_vld` low in the next cycle, and leaves `out_data` unchanged. `out_err` is low in all other cycles.
- R9: A size code of 3 with `dst64` = 1 passes all 64 bits through unchanged, whatever the value of `sext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Request strobe |
| rd_data | input | 64 | Raw read beat |
| addr_lo | input | 3 | Byte offset within the beat |
| size | input | 2 | Item size code |
| sext | input | 1 | 1 = sign fill, 0 = zero fill |
| dst64 | input | 1 | 1 = 64-bit view, 0 = 32-bit view |
| out_vld | output | 1 | Result valid |
| out_data | output | 64 | Formatted write value |
| out_err | output | 1 | Illegal size and view combination |

## Verification
The only state in the block is the output register. A fault in the lane shift, the fill or the view masking therefore shows on `out_data` one cycle after the strobe. The error path and the hold behaviour show on `out_vld` and `out_err` in that same cycle.

A reference model in the bench sweeps every offset, size, fill and view combination over patterns with both top-bit polarities. A wrong lane, a wrong fill bit or leaked upper bits are each visible on the first affected request.

// File: rtl/ld_extend.sv
module ld_extend #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] rd_data,
  input  logic [2:0]    addr_lo,
  input  logic [1:0]    size,
  input  logic          sext,
  input  logic          dst64,
  output logic          out_vld,
  output logic [DW-1:0] out_data,
  output logic          out_err
);
  localparam int HW = DW / 2;

  logic [2:0]    amask;
  logic [2:0]    aoff;
  logic [DW-1:0] shd;
  logic          sbit;
  logic [DW-1:0] ext;
  logic [DW-1:0] fmt;
  logic          bad;

  assign amask = (size == 2'd0) ? 3'b111 :
                 (size == 2'd1) ? 3'b110 :
                 (size == 2'd2) ? 3'b100 : 3'b000;
  assign aoff  = addr_lo & amask;
  assign shd   = rd_data >> {aoff, 3'b000};
  assign bad   = (size == 2'd3) && !dst64;

  always_comb begin
    case (size)
      2'd0:    sbit = sext & shd[7];
      2'd1:    sbit = sext & shd[15];
      2'd2:    sbit = sext & shd[31];
      default: sbit = 1'b0;
    endcase
    case (size)
      2'd0:    ext = {{(DW-8){sbit}},  shd[7:0]};
      2'd1:    ext = {{(DW-16){sbit}}, shd[15:0]};
      2'd2:    ext = {{(DW-32){sbit}}, shd[31:0]};
      default: ext = shd;
    endcase
  end

  assign fmt = dst64 ? ext : {{HW{1'b0}}, ext[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_err  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld && !bad;
      out_err <= in_vld && bad;
      if (in_vld && !bad) out_data <= fmt;
    end
  end

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_data));
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && !sext && size == 2'd0 && dst64) |-> out_data[DW-1:8] == '0);
  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && !dst64 && size != 2'd3) |-> (out_vld && out_data[DW-1:HW] == '0));
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && !dst64 && size == 2'd3) |-> (out_err && !out_vld));
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_err && out_vld));
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_vld && dst64 && size == 2'd3) |-> out_data == $past(rd_data));
endmodule

// File: tb/ld_extend_bench.sv
module ld_extend_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [63:0] rd_data = '0;
  logic [2:0]  addr_lo = '0;
  logic [1:0]  size = '0;
  logic        sext = 1'b0;
  logic        dst64 = 1'b0;
  logic        out_vld;
  logic [63:0] out_data;
  logic        out_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ld_extend u_ld_extend (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .rd_data(rd_data),
    .addr_lo(addr_lo), .size(size), .sext(sext), .dst64(dst64),
    .out_vld(out_vld), .out_data(out_data), .out_err(out_err)
  );

  function automatic logic [63:0] model(input logic [63:0] d, input int a,
                                        input int sz, input bit s, input bit w64);
    logic [63:0] r;
    int nb;
    int off;
    r = '0;
    nb = 1 << sz;
    off = (a / nb) * nb;
    for (int i = 0; i < nb; i++) r[8*i +: 8] = d[8*(off+i) +: 8];
    if (s && r[8*nb-1])
      for (int j = 8*nb; j < 64; j++) r[j] = 1'b1;
    if (!w64) r[63:32] = '0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic req(input logic [63:0] d, input int a, input int sz,
                     input bit s, input bit w64);
    @(negedge clk);
    rd_data = d; addr_lo = 3'(a); size = 2'(sz); sext = s; dst64 = w64;
    in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_vld == 0 && out_err == 0 && out_data == 0, "R1 reset",
        {62'd0, out_vld, out_err} | out_data, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_sign_examples;
    req(64'h0000_0000_0000_008A, 0, 0, 1, 0);
    chk(out_vld && out_data == 64'h0000_0000_FFFF_FF8A, "R6 signed byte 32-bit view",
        out_data, 64'h0000_0000_FFFF_FF8A);
    req(64'h0000_0000_0000_008A, 0, 0, 1, 1);
    chk(out_vld && out_data == 64'hFFFF_FFFF_FFFF_FF8A, "R5 signed byte 64-bit view",
        out_data, 64'hFFFF_FFFF_FFFF_FF8A);
    req(64'h0000_0000_0000_008A, 0, 0, 0, 1);
    chk(out_vld && out_data == 64'h0000_0000_0000_008A, "R4 unsigned byte",
        out_data, 64'h0000_0000_0000_008A);
  endtask

  task automatic t_lanes;
    for (int a = 0; a < 8; a++) begin
      req(64'h8877_6655_4433_2211, a, 0, 0, 1);
      chk(out_data == 64'(8'h11 * (a + 1)), "R3 byte lane", out_data,
          64'(8'h11 * (a + 1)));
    end
    req(64'h8877_6655_4433_2211, 7, 1, 0, 1);
    chk(out_data == 64'h8877, "R3 half alignment", out_data, 64'h8877);
    req(64'h8877_6655_4433_2211, 6, 2, 0, 1);
    chk(out_data == 64'h8877_6655, "R3 word alignment", out_data, 64'h8877_6655);
  endtask

  task automatic t_word32;
    req(64'hF000_0000_9234_5678, 0, 2, 1, 0);
    chk(out_data == 64'h0000_0000_9234_5678, "R7 signed word 32-bit view",
        out_data, 64'h0000_0000_9234_5678);
  endtask

  task automatic t_illegal;
    logic [63:0] prev;
    req(64'h1234_5678_9ABC_DEF0, 0, 3, 1, 1);
    chk(out_vld && out_data == 64'h1234_5678_9ABC_DEF0, "R9 doubleword pass",
        out_data, 64'h1234_5678_9ABC_DEF0);
    prev = out_data;
    req(64'hDEAD_BEEF_DEAD_BEEF, 0, 3, 0, 0);
    chk(out_err && !out_vld, "R8 illegal flags", {62'd0, out_vld, out_err}, 64'd1);
    chk(out_data == prev, "R8 data unchanged", out_data, prev);
    @(negedge clk);
    chk(!out_err, "R8 error is a pulse", {63'd0, out_err}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] prev;
    req(64'h0000_0000_0000_00C3, 0, 0, 1, 1);
    prev = out_data;
    @(negedge clk);
    rd_data = '1;
    @(negedge clk);
    chk(!out_vld && out_data == prev, "R2 hold without strobe", out_data, prev);
  endtask

  task automatic t_sweep;
    logic [63:0] pats [3];
    logic [63:0] e;
    pats[0] = 64'h8F7E_6D5C_4B3A_2918;
    pats[1] = 64'h7FFF_0080_8000_7F80;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 8; a++)
        for (int sz = 0; sz < 4; sz++)
          for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++) begin
              req(pats[p], a, sz, s[0], w[0]);
              if (sz == 3 && w == 0)
                chk(out_err && !out_vld, "R8 sweep", {62'd0, out_vld, out_err}, 64'd1);
              else begin
                e = model(pats[p], a, sz, s[0], w[0]);
                chk(out_vld && !out_err && out_data == e, "R3 R4 R5 R6 R9 sweep",
                    out_data, e);
              end
            end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset;
    t_sign_examples;
    t_lanes;
    t_word32;
    t_illegal;
    t_hold;
    t_sweep;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule